// File: doc/BRIEF.md
# Table-Mixing Byte Scrambler with LFSR Key Stream

The block scrambles a stream of bytes. Each accepted byte draws a fresh 14-bit key from a free-running Galois LFSR. The key selects two entries of a 256-byte table that rewrites itself as it runs, picks which of the two bytes the input byte is folded into, and sets a rotate amount. The two bytes are packed into a 32-bit word, which is rotated left.

The upper byte of the rotated word is added to the previous feedback byte and to a stored carry. The result is the new feedback byte, and the bit that overflows becomes the carry for the next byte. The new feedback byte overwrites the primary table entry. One cycle later it is added to the lower byte of the rotated word to form the scrambled output. Because of this, each output depends on the current byte, on earlier bytes through the feedback chain, and on the history of the table.

The LFSR takes nothing from the data path. Its state cannot be recovered from the output. It can be reseeded at any time.

Top module: `tblmix_scrambler`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears `out_vld`, `out_data`, the feedback byte and the carry. It sets every table entry to its own index and sets the LFSR state to 1.
- R2: Each accepted byte (`in_vld` high) advances the LFSR by exactly 14 right-shift Galois steps. Each step takes the state's bit 0 as the next key bit, shifts the state right, and XORs in the tap mask when that bit was 1. Key bit 0 is the select bit. Key bits 1..8 are the index (bit 1 is the index LSB). Key bits 9..13 are the rotate amount (bit 9 is the LSB).
- R3: The first byte A is read from entry `idx` and the second byte B from entry `idx ^ 8'hFF`. The input byte is XORed into A when the select bit is 0, and into B when it is 1.
- R4: The 32-bit word is {A, B, B, A}, with A in bits 31:24. It is rotated left by the rotate amount.
- R5: The new feedback byte is the low 8 bits of (rotated bits 31:24 + previous feedback byte + stored carry). Bit 8 of that sum becomes the stored carry.
- R6: The output byte is (rotated bits 7:0 + new feedback byte) mod 256. A byte accepted at edge k is flagged by `out_vld` after edge k+1, which is two register stages. `out_data` holds its value while `out_vld` is low.
- R7: Each accepted byte writes its new feedback byte into entry `idx`, and the following byte sees the new value.
- R8: While `in_vld` is low, the table, the LFSR, the feedback byte and the carry do not change.
- R9: `seed_ld` loads `seed_val` into the LFSR, and a zero seed loads 1 instead. The load takes priority over the advance. A byte accepted in the same cycle uses the key from the state before the load.
- R10: `LFSR_W` = 8 uses tap mask 8'hB8. `LFSR_W` = 32 uses tap mask 32'h80200003. Neither the output nor the feedback byte ever enters the LFSR.
- R11: The LFSR state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| seed_ld | input | 1 | Load the LFSR seed |
| seed_val | input | LFSR_W | Seed value |
| out_vld | output | 1 | Output byte valid |
| out_data | output | 8 | Scrambled output byte |

## Verification
The bench builds two copies side by side, one with `LFSR_W` = 8 and one with `LFSR_W` = 32, and drives both with the same stimulus. The 8-bit copy wraps its key sequence every 255 steps. Over a few thousand bytes this exercises repeated table indices, every rotate amount and repeated rewrites of the same entries. The 32-bit copy checks the long tap mask against an independent model. The stimulus includes zero seeds, seed loads that coincide with valid bytes, idle gaps, and runs of constant data that push the feedback carry.

// File: rtl/tms_pkg.sv
package tms_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 4 * BYTE_W;
    localparam int SEL_W   = 1;
    localparam int IDX_W   = 8;
    localparam int ROT_W   = $clog2(WORD_W);
    localparam int KEY_W   = SEL_W + IDX_W + ROT_W;
    localparam int TBL_DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [ROT_W-1:0] rot;
        logic [IDX_W-1:0] idx;
        logic             sel;
    } key_t;

    // Right-shift Galois tap masks for the supported widths
    function automatic logic [31:0] tap_mask(input int width);
        if (width == 8) return 32'h0000_00B8;
        return 32'h8020_0003;
    endfunction

endpackage

// File: rtl/tms_lfsr.sv
module tms_lfsr
    import tms_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         seed_ld,
    input  logic [W-1:0] seed_val,
    output key_t         key
);

    localparam logic [W-1:0] MASK = W'(tap_mask(W));
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] state;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;
    logic [KEY_W-1:0] bits;
    logic [W-1:0]     walk;

    always_comb begin
        walk = st_q.state;
        bits = '0;
        for (int i = 0; i < KEY_W; i++) begin
            logic lsb;
            lsb     = walk[0];
            bits[i] = lsb;
            walk    = (walk >> 1) ^ (lsb ? MASK : '0);
        end
        key = key_t'(bits);

        st_d = st_q;
        if (seed_ld)
            st_d.state = (seed_val == '0) ? ONE : seed_val;
        else if (adv)
            st_d.state = walk;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{state: ONE};
        else     st_q <= st_d;
    end

    assert_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
        st_q.state != '0);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!adv && !seed_ld) |=> $stable(st_q.state));

    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && !seed_ld) |=> st_q.state != $past(st_q.state));

    assert_seed_load_R9: assert property (@(posedge clk) disable iff (rst)
        seed_ld |=> st_q.state == (($past(seed_val) == '0) ? ONE : $past(seed_val)));

endmodule

// File: rtl/tms_table.sv
module tms_table
    import tms_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH,
    parameter int DW    = BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] addr_a,
    input  logic [$clog2(DEPTH)-1:0] addr_b,
    output logic [DW-1:0]            data_a,
    output logic [DW-1:0]            data_b,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DW-1:0]            wr_data
);

    logic [DW-1:0] mem_q [DEPTH];

    assign data_a = mem_q[addr_a];
    assign data_b = mem_q[addr_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= DW'(i);
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

    assert_read_ports_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> addr_a != addr_b);

endmodule

// File: rtl/tms_mix.sv
module tms_mix
    import tms_pkg::*;
(
    input  logic [BYTE_W-1:0] tbl_a,
    input  logic [BYTE_W-1:0] tbl_b,
    input  logic [BYTE_W-1:0] din,
    input  key_t              key,
    input  logic [BYTE_W-1:0] fb_prev,
    input  logic              carry_in,
    output logic [BYTE_W-1:0] fb_next,
    output logic              carry_out,
    output logic [BYTE_W-1:0] low_byte
);

    logic [BYTE_W-1:0]   a_m, b_m;
    logic [WORD_W-1:0]   word;
    logic [2*WORD_W-1:0] dbl;
    logic [WORD_W-1:0]   rotw;
    logic [BYTE_W:0]     sum;

    always_comb begin
        a_m  = key.sel ? tbl_a : (tbl_a ^ din);
        b_m  = key.sel ? (tbl_b ^ din) : tbl_b;
        word = {a_m, b_m, b_m, a_m};
        dbl  = {word, word} << key.rot;
        rotw = dbl[2*WORD_W-1:WORD_W];
        sum  = (BYTE_W+1)'(rotw[WORD_W-1 -: BYTE_W])
             + (BYTE_W+1)'(fb_prev)
             + (BYTE_W+1)'(carry_in);
        fb_next   = sum[BYTE_W-1:0];
        carry_out = sum[BYTE_W];
        low_byte  = rotw[BYTE_W-1:0];
    end

endmodule

// File: rtl/tblmix_scrambler.sv
module tblmix_scrambler
    import tms_pkg::*;
#(
    parameter int LFSR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [7:0]        in_data,
    input  logic              seed_ld,
    input  logic [LFSR_W-1:0] seed_val,
    output logic              out_vld,
    output logic [7:0]        out_data
);

    typedef struct packed {
        logic              s1_vld;
        logic [BYTE_W-1:0] s1_low;
        logic [BYTE_W-1:0] fb;
        logic              carry;
        logic              o_vld;
        logic [BYTE_W-1:0] o_data;
    } core_st_t;

    core_st_t core_d, core_q;

    key_t              key;
    logic [BYTE_W-1:0] rd_a, rd_b;
    logic [BYTE_W-1:0] mix_fb, mix_low;
    logic              mix_carry;

    tms_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .adv      (in_vld),
        .seed_ld  (seed_ld),
        .seed_val (seed_val),
        .key      (key)
    );

    tms_table #(.DEPTH(TBL_DEPTH), .DW(BYTE_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .addr_a  (key.idx),
        .addr_b  (key.idx ^ {IDX_W{1'b1}}),
        .data_a  (rd_a),
        .data_b  (rd_b),
        .wr_en   (in_vld),
        .wr_addr (key.idx),
        .wr_data (mix_fb)
    );

    tms_mix u_mix (
        .tbl_a     (rd_a),
        .tbl_b     (rd_b),
        .din       (in_data),
        .key       (key),
        .fb_prev   (core_q.fb),
        .carry_in  (core_q.carry),
        .fb_next   (mix_fb),
        .carry_out (mix_carry),
        .low_byte  (mix_low)
    );

    always_comb begin
        core_d        = core_q;
        core_d.s1_vld = in_vld;
        if (in_vld) begin
            core_d.s1_low = mix_low;
            core_d.fb     = mix_fb;
            core_d.carry  = mix_carry;
        end
        core_d.o_vld = core_q.s1_vld;
        if (core_q.s1_vld)
            core_d.o_data = core_q.s1_low + core_q.fb;
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '0;
        else     core_q <= core_d;
    end

    assign out_vld  = core_q.o_vld;
    assign out_data = core_q.o_data;

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> ##2 out_vld);

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        !in_vld |-> ##2 !out_vld);

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> $stable(out_data));

    assert_idle_fb_R8: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(core_q.fb) && $stable(core_q.carry)));

endmodule

// File: tb/test_tblmix_scrambler.sv
module test_tblmix_scrambler;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [7:0]  in_data = '0;
    logic        seed_ld = 1'b0;
    logic [31:0] seed_val = '0;

    logic       vld32, vld8;
    logic [7:0] dat32, dat8;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tblmix_scrambler #(.LFSR_W(32)) i_tblmix_scrambler (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
        .seed_ld(seed_ld), .seed_val(seed_val),
        .out_vld(vld32), .out_data(dat32)
    );

    tblmix_scrambler #(.LFSR_W(8)) i_tblmix_scrambler_w8 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
        .seed_ld(seed_ld), .seed_val(seed_val[7:0]),
        .out_vld(vld8), .out_data(dat8)
    );

    // Behavioural reference: lane 0 = 8-bit LFSR, lane 1 = 32-bit LFSR
    int        m_tbl [2][256];
    bit [31:0] m_lf [2];
    int        m_fb [2], m_cy [2];
    bit        m_s1v [2], m_ov [2];
    int        m_s1r [2], m_or [2];

    function automatic bit [31:0] lane_mask(int l);
        return (l == 0) ? 32'hB8 : 32'h8020_0003;
    endfunction

    always @(posedge clk) begin
        for (int l = 0; l < 2; l++) begin
            if (rst) begin
                for (int e = 0; e < 256; e++) m_tbl[l][e] = e;
                m_lf[l] = 1; m_fb[l] = 0; m_cy[l] = 0;
                m_s1v[l] = 0; m_ov[l] = 0; m_s1r[l] = 0; m_or[l] = 0;
            end else begin
                bit [31:0] s;
                bit        kb [14];
                int sel, idx, rot, a, b, hi, lo, sum;
                bit [31:0] w;
                m_ov[l] = m_s1v[l];
                if (m_s1v[l]) m_or[l] = m_s1r[l];
                m_s1v[l] = in_vld;
                s = m_lf[l];
                for (int k = 0; k < 14; k++) begin
                    kb[k] = s[0];
                    if (s[0]) s = (s >> 1) ^ lane_mask(l);
                    else      s = s >> 1;
                end
                if (in_vld) begin
                    sel = kb[0];
                    idx = 0; rot = 0;
                    for (int j = 0; j < 8; j++) idx += int'(kb[1+j]) << j;
                    for (int j = 0; j < 5; j++) rot += int'(kb[9+j]) << j;
                    a = m_tbl[l][idx];
                    b = m_tbl[l][idx ^ 255];
                    if (sel == 0) a = a ^ int'(in_data);
                    else          b = b ^ int'(in_data);
                    w = {a[7:0], b[7:0], b[7:0], a[7:0]};
                    w = (w << rot) | (w >> (32 - rot));
                    hi = int'(w[31:24]); lo = int'(w[7:0]);
                    sum = hi + m_fb[l] + m_cy[l];
                    m_fb[l] = sum % 256;
                    m_cy[l] = sum / 256;
                    m_tbl[l][idx] = m_fb[l];
                    m_s1r[l] = (lo + m_fb[l]) % 256;
                    m_lf[l] = s;
                end
                if (seed_ld) begin
                    bit [31:0] sv;
                    sv = (l == 0) ? {24'd0, seed_val[7:0]} : seed_val;
                    m_lf[l] = (sv == 0) ? 32'd1 : sv;
                end
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            check(cur_req, "w8 out_vld",   int'(vld8),  int'(m_ov[0]));
            check(cur_req, "w8 out_data",  int'(dat8),  m_or[0]);
            check(cur_req, "w32 out_vld",  int'(vld32), int'(m_ov[1]));
            check(cur_req, "w32 out_data", int'(dat32), m_or[1]);
        end
    end

    task automatic step(bit v, int d, bit sl, bit [31:0] sv);
        @(negedge clk);
        #1;
        in_vld = v; in_data = d[7:0]; seed_ld = sl; seed_val = sv;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state visible at the ports
        cur_req = "R1";
        check("R1", "w32 out_vld after reset", int'(vld32), 0);
        check("R1", "w32 out_data after reset", int'(dat32), 0);
        check("R1", "w8 out_vld after reset", int'(vld8), 0);
        check("R1", "w8 out_data after reset", int'(dat8), 0);
        cmp_on = 1'b1;

        // R1 R3: first bytes read the identity table
        cur_req = "R1 R3";
        step(1, 8'h00, 0, 0);
        step(1, 8'h5A, 0, 0);
        step(0, 0, 0, 0);
        repeat (3) step(0, 0, 0, 0);

        // R6: isolated bytes, latency and hold of out_data
        cur_req = "R6";
        for (int i = 0; i < 6; i++) begin
            step(1, 17 * i + 3, 0, 0);
            repeat (4) step(0, 8'hFF, 0, 0);
        end

        // R2 R3 R4 R5 R7 R10: long burst with varied data
        cur_req = "R2 R3 R4 R5 R7 R10";
        for (int i = 0; i < 1500; i++) step(1, int'($urandom_range(0, 255)), 0, 0);
        step(0, 0, 0, 0);

        // R8: random idle gaps; idle data must not matter
        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            bit v;
            v = ($urandom_range(0, 2) != 0);
            step(v, int'($urandom_range(0, 255)), 0, 0);
        end

        // R9: seed loads alone, with a byte, and zero seeds
        cur_req = "R9";
        step(0, 0, 1, 32'hDEAD_BEEF);
        for (int i = 0; i < 40; i++) step(1, i, 0, 0);
        step(1, 8'hC3, 1, 32'h0000_0000);
        for (int i = 0; i < 40; i++) step(1, 255 - i, 0, 0);
        step(0, 0, 1, 32'h1234_5600);
        for (int i = 0; i < 40; i++) step(1, 8'h77, 0, 0);
        step(1, 8'h11, 1, 32'h0000_00A5);
        for (int i = 0; i < 40; i++) step(i % 3 != 0, i * 7, 0, 0);

        // R11 R5: zero seed then constant data runs exercise carry
        cur_req = "R11 R5";
        step(0, 0, 1, 32'h0);
        for (int i = 0; i < 800; i++) step(1, 8'hFF, 0, 0);
        for (int i = 0; i < 400; i++) step(1, 8'h00, 0, 0);

        // R1: mid-run reset returns to the identity table
        cur_req = "R1";
        step(0, 0, 0, 0);
        rst = 1'b1;
        repeat (2) step(0, 0, 0, 0);
        rst = 1'b0;
        for (int i = 0; i < 30; i++) step(1, i * 13, 0, 0);
        repeat (4) step(0, 0, 0, 0);

        finish_run();
    end

endmodule